// File: doc/BRIEF.md
# Split Two-Section Falling-Edge Counter

This block is a 4-bit binary counter made of two sections that count separately. The lower section is a single toggle stage, and it advances on falling edges of its own count input. The upper section is a 3-bit binary stage with its own count input. The whole block runs on one system clock. It samples both count inputs through synchronizers and finds their high-to-low transitions. It then advances the matching section, and the outputs update together in a single clock cycle. Because of this, the intermediate ripple states never show at the outputs.

There are three ways to use the counter:
- As a 4-bit counter with external wiring: feed `q_out[0]` back into `cnt_hi_in`.
- As a 4-bit counter with internal chaining: set `chain_mode`, and the lower stage's wrap from 1 to 0 carries into the upper section inside the same cycle.
- As a 3-bit counter on its own, driven from `cnt_hi_in` alone.

A clear needs two qualifier inputs, and it takes effect only while both are high. It is synchronized to the system clock, and it overrides counting. The system `rst` is a synchronous active-high reset of every flop.

Top module: `split_ripple_counter`

## Requirements
- R1: While `rst` is high at a clock edge, every flop is cleared. After `rst` is released, `q_out` reads 4'b0000.
- R2: A high-to-low transition on `cnt_lo_in` toggles `q_out[0]`.
  - The new value appears after the third rising clock edge that follows the input change.
  - After the second rising edge, the old value is still shown.
  - Low-to-high transitions have no effect.
- R3: With `chain_mode` low, each high-to-low transition on `cnt_hi_in` adds one, modulo 8, to `q_out[3:1]`, with `q_out[1]` as the least significant bit. `q_out[0]` is left unchanged.
- R4: While `clr_a_in` and `clr_b_in` are both high, all four outputs are forced to 0 from the third rising edge on, and falling edges on the count inputs are discarded.
- R5: When only one of `clr_a_in` and `clr_b_in` is high, both sections count exactly as if neither were high.
- R6: With `chain_mode` high, each falling edge of `cnt_lo_in` adds one, modulo 16, to `q_out`, with bit 0 as the least significant bit.
  - A carry from `q_out[0]` into the upper section lands in the same cycle, so there is no intermediate value.
  - Falling edges on `cnt_hi_in` are ignored.
  - `chain_mode` is held steady while counting.
- R7: A count-input falling edge that reaches the block during a clear, or in the cycle the clear is released, is discarded. The first falling edge after the clear ends sets `q_out[0]` to 1.
- R8: With `chain_mode` low, falling edges that arrive together on both count inputs advance both sections in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_lo_in | input | 1 | Count pulses for the one-bit lower section (asynchronous) |
| cnt_hi_in | input | 1 | Count pulses for the three-bit upper section (asynchronous) |
| clr_a_in | input | 1 | Clear qualifier A; a clear occurs only when both qualifiers are high |
| clr_b_in | input | 1 | Clear qualifier B |
| chain_mode | input | 1 | 1: lower-stage wrap drives the upper section; 0: sections independent |
| q_out | output | 4 | Stage bits, bit 0 from the lower section, bits 3:1 from the upper |

## Verification
A wrong lower-stage bit shows at `q_out[0]` at the next observation, three edges after the input fall. A stuck or mis-wired carry only shows when the lower stage wraps from 1 to 0 in chain mode, so the bench walks the full 0..15 cycle. It then checks the 7-to-8 step cycle by cycle, so that a lagging carry would be seen. A clear that lets an edge leak through shows up as a nonzero `q_out` right after release, before any fresh pulse.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int unsigned LO_W        = 1;
  localparam int unsigned HI_W        = 3;
  localparam int unsigned Q_W         = LO_W + HI_W;
  localparam int unsigned SYNC_DEPTH  = 2;
  // input channel indices into the synchronizer bank
  localparam int unsigned CH_LO  = 0;
  localparam int unsigned CH_HI  = 1;
  localparam int unsigned CH_CLR = 2;
  localparam int unsigned N_CH   = 3;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned N     = 3,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] fall
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ch
      logic [DEPTH-1:0] sh;
      logic             hist;
      always_ff @(posedge clk) begin
        if (rst) begin
          sh   <= '0;
          hist <= 1'b0;
        end else begin
          sh   <= {sh[DEPTH-2:0], din[g]};
          hist <= sh[DEPTH-1];
        end
      end
      assign level[g] = sh[DEPTH-1];
      assign fall[g]  = hist & ~sh[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/count_section.sv
module count_section #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] q,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (adv)   q <= q + ONE;
  end
  assign wrap = adv & (&q);
endmodule

// File: rtl/split_ripple_counter.sv
module split_ripple_counter
  import spc_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           cnt_lo_in,
  input  logic           cnt_hi_in,
  input  logic           clr_a_in,
  input  logic           clr_b_in,
  input  logic           chain_mode,
  output logic [Q_W-1:0] q_out
);
  logic [N_CH-1:0] raw, lvl, fall;
  logic            clr_s, clr_d, quiet;
  logic            adv_lo, adv_hi, wrap_lo, wrap_hi;
  logic [LO_W-1:0] q_lo;
  logic [HI_W-1:0] q_hi;

  always_comb begin
    raw         = '0;
    raw[CH_LO]  = cnt_lo_in;
    raw[CH_HI]  = cnt_hi_in;
    raw[CH_CLR] = clr_a_in & clr_b_in;
  end

  edge_sync #(.N(N_CH), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .din(raw), .level(lvl), .fall(fall)
  );

  assign clr_s = lvl[CH_CLR];
  always_ff @(posedge clk) begin
    if (rst) clr_d <= 1'b0;
    else     clr_d <= clr_s;
  end
  // edges during a clear and in its release cycle are dropped
  assign quiet  = clr_s | clr_d;
  assign adv_lo = fall[CH_LO] & ~quiet;
  assign adv_hi = (chain_mode ? wrap_lo : fall[CH_HI]) & ~quiet;

  count_section #(.W(LO_W)) u_lo (
    .clk(clk), .rst(rst), .clr(clr_s), .adv(adv_lo), .q(q_lo), .wrap(wrap_lo)
  );
  count_section #(.W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .clr(clr_s), .adv(adv_hi), .q(q_hi), .wrap(wrap_hi)
  );

  assign q_out = {q_hi, q_lo};
endmodule

// File: rtl/spc_chk.sv
module spc_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_lo_in,
  input logic         clr_a_in,
  input logic         clr_b_in,
  input logic         chain_mode,
  input logic [W-1:0] q_out
);
  logic [2:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)           cyc <= '0;
    else if (cyc != 7) cyc <= cyc + 3'd1;
  end

  // R2
  lo_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 5 && $rose(q_out[0])) |-> ($past(cnt_lo_in, 4) && !$past(cnt_lo_in, 3)));

  // R3
  hi_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 1 && q_out[W-1:1] != $past(q_out[W-1:1])) |->
      (q_out[W-1:1] == '0 || q_out[W-1:1] == $past(q_out[W-1:1]) + 1'b1));

  // R4
  clear_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 4 && $past(clr_a_in & clr_b_in, 1) && $past(clr_a_in & clr_b_in, 2)
      && $past(clr_a_in & clr_b_in, 3)) |-> (q_out == '0));

  // R6
  chain_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 1 && chain_mode && $past(chain_mode) && q_out != $past(q_out)) |->
      (q_out == '0 || q_out == $past(q_out) + 1'b1));
endmodule

bind split_ripple_counter spc_chk #(.W(spc_pkg::Q_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_lo_in(cnt_lo_in), .clr_a_in(clr_a_in),
  .clr_b_in(clr_b_in), .chain_mode(chain_mode), .q_out(q_out)
);

// File: tb/sim_split_ripple_counter.sv
module sim_split_ripple_counter;
  logic       clk = 1'b0;
  logic       rst, ca, cb, ma, mb, chain;
  logic [3:0] q, exp_q;
  int         total = 0, bad = 0;

  always #5 clk = ~clk;

  split_ripple_counter u0 (
    .clk(clk), .rst(rst), .cnt_lo_in(ca), .cnt_hi_in(cb),
    .clr_a_in(ma), .clr_b_in(mb), .chain_mode(chain), .q_out(q)
  );

  function automatic logic [3:0] step(logic [3:0] e, bit fa, bit fb, bit ch);
    logic       lo, adv;
    logic [2:0] hi;
    lo  = e[0];
    hi  = e[3:1];
    adv = ch ? (fa && lo) : fb;
    if (fa)  lo = ~lo;
    if (adv) hi = hi + 3'd1;
    return {hi, lo};
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] e);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, e);
    end
  endtask

  task automatic wn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit fa, bit fb, string req);
    if (fa) ca = 1'b0;
    if (fb) cb = 1'b0;
    wn(5);
    ca = 1'b1; cb = 1'b1;
    wn(5);
    exp_q = step(exp_q, fa, fb, chain);
    chk(req, q, exp_q);
  endtask

  task automatic do_clear();
    ma = 1'b1; mb = 1'b1;
    wn(5);
    chk("R4", q, 4'h0);
    ma = 1'b0; mb = 1'b0;
    wn(4);
    exp_q = 4'h0;
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; ca = 1'b1; cb = 1'b1; ma = 1'b0; mb = 1'b0; chain = 1'b0;
    exp_q = 4'h0;
    wn(4);
    rst = 1'b0;
    wn(4);
    chk("R1", q, 4'h0);

    // R2 exact latency and rising-edge immunity
    ca = 1'b0;
    wn(2); chk("R2", q, 4'h0);
    wn(1); chk("R2", q, 4'h1);
    ca = 1'b1;
    wn(5); chk("R2", q, 4'h1);
    exp_q = 4'h1;

    // R3 upper section wraps modulo 8, Q0 untouched
    for (int i = 0; i < 9; i++) pulse(1'b0, 1'b1, "R3");

    // R8 simultaneous edges
    pulse(1'b1, 1'b1, "R8");
    pulse(1'b1, 1'b1, "R8");

    // R5 single qualifier does not clear
    ma = 1'b1;
    pulse(1'b1, 1'b1, "R5");
    ma = 1'b0; mb = 1'b1;
    pulse(1'b0, 1'b1, "R5");
    mb = 1'b0;

    // R4 clear, edges during clear dropped; R7 release behaviour
    ma = 1'b1; mb = 1'b1;
    wn(5); chk("R4", q, 4'h0);
    ca = 1'b0; cb = 1'b0;
    wn(5); chk("R4", q, 4'h0);
    ca = 1'b1; cb = 1'b1;
    wn(3);
    ma = 1'b0; mb = 1'b0;
    ca = 1'b0;
    wn(6); chk("R7", q, 4'h0);
    ca = 1'b1;
    wn(5);
    exp_q = 4'h0;
    pulse(1'b1, 1'b0, "R7");

    // R6 chained full cycle, CP1 ignored
    do_clear();
    chain = 1'b1;
    for (int i = 0; i < 7; i++) pulse(1'b1, 1'b0, "R6");
    pulse(1'b0, 1'b1, "R6");
    ca = 1'b0;
    wn(2); chk("R6", q, 4'h7);
    wn(1); chk("R6", q, 4'h8);
    ca = 1'b1; wn(5);
    exp_q = 4'h8;
    for (int i = 0; i < 8; i++) pulse(1'b1, 1'b0, "R6");
    chk("R6", q, 4'h0);

    // random mix
    for (int i = 0; i < 150; i++) begin
      int op;
      op = int'($urandom % 7);
      case (op)
        0: pulse(1'b1, 1'b0, chain ? "R6" : "R2");
        1: pulse(1'b0, 1'b1, chain ? "R6" : "R3");
        2: pulse(1'b1, 1'b1, chain ? "R6" : "R8");
        3: begin ma = $urandom % 2; mb = ~ma; pulse(1'b1, 1'b1, "R5"); ma = 0; mb = 0; end
        4: if (($urandom % 4) == 0) do_clear(); else pulse(1'b1, 1'b0, "R2");
        5: chain = ~chain;
        default: pulse(1'b0, 1'b1, "R3");
      endcase
    end

    // R1 mid-run reset
    chain = 1'b0;
    pulse(1'b1, 1'b1, "R8");
    rst = 1'b1; wn(3); rst = 1'b0; wn(3);
    chk("R1", q, 4'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule